// File: doc/BRIEF.md
# Clock Source Switching Sequencer

This block is a hardware sequencer that moves the core clock between three sources: an internal ring oscillator, an external crystal oscillator, and a PLL. It drives the enable, select, bypass, reference and divider controls of those sources. It watches their ready and lock flags and a slow real-time tick pulse. A one-cycle request chooses the target mode. The block then performs the writes one per cycle in a fixed order and reports its progress with `busy` and a one-cycle `done`.

Every request starts with the same fallback. The ring oscillator is enabled and loaded with its default divider and trim, and the sequencer waits for it to report ready. Only then does the core leave the PLL path. The PLL is then parked: bypassed, referenced to the ring oscillator, with the crystal powered down. For the external and PLL modes, the sequencer next powers the crystal and waits for it. It then applies the PLL settings and, in PLL mode only, waits a fixed number of tick pulses before it trusts the lock flag. After that it selects the PLL path and powers down the ring oscillator. Each of the three waits is guarded by an optional timeout. A timeout sets an error flag and leaves the core on the ring oscillator.

States:
- IDLE accepts a request and goes to ROSC_ON.
- ROSC_ON waits for the ring-oscillator ready flag, then goes to ROSC_SEL. On timeout it goes to FAIL.
- ROSC_SEL goes to PLL_PARK.
- PLL_PARK goes to XOSC_OFF.
- XOSC_OFF goes to DONE for the internal target, and to XOSC_ON otherwise.
- XOSC_ON waits for the crystal ready flag, then goes to PLL_CFG. On timeout it goes to FAIL.
- PLL_CFG goes to PLL_SEL for the external target, and to LOCK_DLY for the PLL target.
- LOCK_DLY counts tick pulses, then goes to LOCK_WAIT.
- LOCK_WAIT waits for lock, then goes to PLL_SEL. On timeout it goes to FAIL.
- PLL_SEL goes to ROSC_OFF, and ROSC_OFF goes to DONE.
- FAIL goes to FAIL_PARK, and FAIL_PARK goes to DONE.
- DONE goes to IDLE.

Top module: `clksrc_sequencer`

## Requirements
- R1: After reset the outputs are as follows: `rosc_en`=1, `rosc_div`=4, `rosc_trim`=16, `xosc_en`=0, `pll_sel`=0, `pll_bypass`=1, `pll_refsel`=0, `pll_mult`=0, `pll_odiv`=0, `pll_odiv_by1`=0, `busy`=0, `done`=0 and `err`=0.
- R2: The `req_mode` encoding is 0 for internal, 1 for external and 2 for PLL. A request is taken only in IDLE with `req_valid`=1 and a mode other than 3. A mode-3 request, or any request while `busy`=1, changes nothing.
- R3: Every accepted request first sets `rosc_en`=1, `rosc_div`=4 and `rosc_trim`=16. It waits for `rosc_ready` while `rosc_en` is high before it clears `pll_sel`. No PLL field changes before `pll_sel` is 0.
- R4: Internal mode ends with `pll_sel`=0, `pll_bypass`=1, `pll_refsel`=0, `xosc_en`=0 and `rosc_en`=1.
- R5: External and PLL modes set `xosc_en`=1 and wait for `xosc_ready` seen while `xosc_en` is high before any PLL configuration is applied.
- R6: External mode ends with `pll_bypass`=1, `pll_refsel`=1, `pll_odiv_by1`=1, `pll_sel`=1, `xosc_en`=1 and `rosc_en`=0. It needs no tick pulses and no lock.
- R7: PLL mode applies `pll_bypass`=0, `pll_refsel`=1, `pll_odiv_by1`=0, and the multiplier and divider captured when the request was accepted. It sets `pll_sel` only after LOCK_TICKS (4) `rtc_tick` pulses and then a high `pll_lock`. `pll_lock` is ignored before those pulses.
- R8: While `pll_sel`=1, none of `pll_bypass`, `pll_refsel`, `pll_mult`, `pll_odiv` or `pll_odiv_by1` changes.
- R9: `rosc_en` falls only while `pll_sel`=1.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is high for exactly one cycle.
- R11: If a waited flag stays low for TIMEOUT_CYC cycles, the sequencer sets `err`=1 and restores the R4 values, then pulses `done`. The next accepted request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Target mode: 0 internal, 1 external, 2 PLL |
| req_pll_mult | input | MULT_W | PLL multiplier for PLL mode |
| req_pll_odiv | input | ODIV_W | PLL output divider for PLL mode |
| rosc_ready | input | 1 | Ring oscillator stable |
| xosc_ready | input | 1 | Crystal oscillator stable |
| pll_lock | input | 1 | PLL lock flag, may glitch |
| rtc_tick | input | 1 | Synchronized single-cycle slow tick |
| rosc_en | output | 1 | Ring oscillator enable |
| rosc_div | output | DIV_W | Ring oscillator divider |
| rosc_trim | output | TRIM_W | Ring oscillator trim |
| xosc_en | output | 1 | Crystal oscillator enable |
| pll_sel | output | 1 | Core clock from PLL path (0: ring oscillator) |
| pll_bypass | output | 1 | PLL bypassed |
| pll_refsel | output | 1 | PLL reference: 1 crystal, 0 ring oscillator |
| pll_mult | output | MULT_W | PLL multiplier |
| pll_odiv | output | ODIV_W | PLL output divider |
| pll_odiv_by1 | output | 1 | PLL output divider forced to 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence timed out |

## Verification
The sequencer is driven through each target from several starting modes, with different oscillator start-up delays and different lock timing.

- External mode with no tick pulses separates a skipped lock wait from one that hangs.
- PLL mode with `pll_lock` held high during the tick delay shows that early lock is ignored.
- PLL mode with lock arriving late shows that the sequencer really waits for lock.
- A return to internal mode from the PLL with a slow ring oscillator shows that the PLL path is kept until the ring oscillator is ready.
- A dead crystal exercises the timeout fallback.
- Mode-3 requests and requests issued mid-sequence check that those requests are ignored.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_EXT  = 2'd1,
        MODE_PLL  = 2'd2,
        MODE_NONE = 2'd3
    } clk_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROSC_ON,
        ST_ROSC_SEL,
        ST_PLL_PARK,
        ST_XOSC_OFF,
        ST_XOSC_ON,
        ST_PLL_CFG,
        ST_LOCK_DLY,
        ST_LOCK_WAIT,
        ST_PLL_SEL,
        ST_ROSC_OFF,
        ST_FAIL,
        ST_FAIL_PARK,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/clksrc_tick_count.sv
module clksrc_tick_count #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic reached
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign reached = (cnt_q == CW'(TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && !reached) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    tick_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TICKS));

endmodule

// File: rtl/clksrc_wait_timer.sv
module clksrc_wait_timer #(
    parameter bit EN    = 1'b1,
    parameter int LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    generate
        if (EN) begin : g_timer
            logic [TW-1:0] cnt_q;

            assign expired = (cnt_q == TW'(LIMIT));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clear) begin
                    cnt_q <= '0;
                end else if (run && !expired) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            // R11
            timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (expired && !clear) |=> expired);
        end else begin : g_no_timer
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst_n, clear, run};
            assign expired   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/clksrc_sequencer.sv
module clksrc_sequencer
    import clksrc_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int TRIM_W      = 5,
    parameter int MULT_W      = 6,
    parameter int ODIV_W      = 6,
    parameter int ROSC_DIV_DF = 4,
    parameter int ROSC_TRM_DF = 16,
    parameter int LOCK_TICKS  = 4,
    parameter bit TIMEOUT_EN  = 1'b1,
    parameter int TIMEOUT_CYC = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [MULT_W-1:0] req_pll_mult,
    input  logic [ODIV_W-1:0] req_pll_odiv,
    input  logic              rosc_ready,
    input  logic              xosc_ready,
    input  logic              pll_lock,
    input  logic              rtc_tick,
    output logic              rosc_en,
    output logic [DIV_W-1:0]  rosc_div,
    output logic [TRIM_W-1:0] rosc_trim,
    output logic              xosc_en,
    output logic              pll_sel,
    output logic              pll_bypass,
    output logic              pll_refsel,
    output logic [MULT_W-1:0] pll_mult,
    output logic [ODIV_W-1:0] pll_odiv,
    output logic              pll_odiv_by1,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [DIV_W-1:0]  DIV_DF  = DIV_W'(ROSC_DIV_DF);
    localparam logic [TRIM_W-1:0] TRIM_DF = TRIM_W'(ROSC_TRM_DF);

    seq_state_e        state_q, state_d;
    clk_mode_e         target_q;
    logic [MULT_W-1:0] mult_hold_q;
    logic [ODIV_W-1:0] odiv_hold_q;

    logic rosc_en_q, xosc_en_q, pll_sel_q, bypass_q, refsel_q, by1_q, err_q;
    logic [DIV_W-1:0]  div_q;
    logic [TRIM_W-1:0] trim_q;
    logic [MULT_W-1:0] mult_q;
    logic [ODIV_W-1:0] odiv_q;

    logic accept, waiting, ticks_done, wait_expired;

    assign accept  = (state_q == ST_IDLE) && req_valid && (req_mode != MODE_NONE);
    assign waiting = (state_q == ST_ROSC_ON) || (state_q == ST_XOSC_ON) ||
                     (state_q == ST_LOCK_WAIT);

    clksrc_tick_count #(.TICKS(LOCK_TICKS)) u_ticks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_LOCK_DLY),
        .tick    (rtc_tick),
        .reached (ticks_done)
    );

    clksrc_wait_timer #(.EN(TIMEOUT_EN), .LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_d != state_q),
        .run     (waiting),
        .expired (wait_expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_d = ST_ROSC_ON;
            ST_ROSC_ON:   if (rosc_en_q && rosc_ready) state_d = ST_ROSC_SEL;
                          else if (wait_expired)       state_d = ST_FAIL;
            ST_ROSC_SEL:  state_d = ST_PLL_PARK;
            ST_PLL_PARK:  state_d = ST_XOSC_OFF;
            ST_XOSC_OFF:  state_d = (target_q == MODE_INT) ? ST_DONE : ST_XOSC_ON;
            ST_XOSC_ON:   if (xosc_en_q && xosc_ready) state_d = ST_PLL_CFG;
                          else if (wait_expired)       state_d = ST_FAIL;
            ST_PLL_CFG:   state_d = (target_q == MODE_EXT) ? ST_PLL_SEL : ST_LOCK_DLY;
            ST_LOCK_DLY:  if (ticks_done) state_d = ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (pll_lock)          state_d = ST_PLL_SEL;
                          else if (wait_expired) state_d = ST_FAIL;
            ST_PLL_SEL:   state_d = ST_ROSC_OFF;
            ST_ROSC_OFF:  state_d = ST_DONE;
            ST_FAIL:      state_d = ST_FAIL_PARK;
            ST_FAIL_PARK: state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Control writes, one group per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q    <= MODE_INT;
            mult_hold_q <= '0;
            odiv_hold_q <= '0;
            rosc_en_q   <= 1'b1;
            div_q       <= DIV_DF;
            trim_q      <= TRIM_DF;
            xosc_en_q   <= 1'b0;
            pll_sel_q   <= 1'b0;
            bypass_q    <= 1'b1;
            refsel_q    <= 1'b0;
            mult_q      <= '0;
            odiv_q      <= '0;
            by1_q       <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    target_q    <= clk_mode_e'(req_mode);
                    mult_hold_q <= req_pll_mult;
                    odiv_hold_q <= req_pll_odiv;
                    err_q       <= 1'b0;
                end
                ST_ROSC_ON: begin
                    rosc_en_q <= 1'b1;
                    div_q     <= DIV_DF;
                    trim_q    <= TRIM_DF;
                end
                ST_ROSC_SEL: pll_sel_q <= 1'b0;
                ST_PLL_PARK: begin
                    bypass_q <= 1'b1;
                    refsel_q <= 1'b0;
                end
                ST_XOSC_OFF: xosc_en_q <= 1'b0;
                ST_XOSC_ON:  xosc_en_q <= 1'b1;
                ST_PLL_CFG: begin
                    refsel_q <= 1'b1;
                    if (target_q == MODE_EXT) begin
                        bypass_q <= 1'b1;
                        by1_q    <= 1'b1;
                    end else begin
                        bypass_q <= 1'b0;
                        by1_q    <= 1'b0;
                        mult_q   <= mult_hold_q;
                        odiv_q   <= odiv_hold_q;
                    end
                end
                ST_PLL_SEL:  pll_sel_q <= 1'b1;
                ST_ROSC_OFF: rosc_en_q <= 1'b0;
                ST_FAIL: begin
                    pll_sel_q <= 1'b0;
                    rosc_en_q <= 1'b1;
                    err_q     <= 1'b1;
                end
                ST_FAIL_PARK: begin
                    bypass_q  <= 1'b1;
                    refsel_q  <= 1'b0;
                    xosc_en_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign rosc_en      = rosc_en_q;
    assign rosc_div     = div_q;
    assign rosc_trim    = trim_q;
    assign xosc_en      = xosc_en_q;
    assign pll_sel      = pll_sel_q;
    assign pll_bypass   = bypass_q;
    assign pll_refsel   = refsel_q;
    assign pll_mult     = mult_q;
    assign pll_odiv     = odiv_q;
    assign pll_odiv_by1 = by1_q;
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_DONE);
    assign err          = err_q;

    // R8
    pll_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_sel_q |=> $stable({bypass_q, refsel_q, mult_q, odiv_q, by1_q}));

    // R3
    rosc_ready_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROSC_SEL) |-> ($past(rosc_ready) && rosc_en_q));

    // R9
    rosc_off_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rosc_en_q) |-> pll_sel_q);

    // R5
    xosc_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_sel_q) |-> (xosc_en_q && refsel_q));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(target_q));

    // R11
    err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (!pll_sel_q && rosc_en_q));

endmodule

// File: tb/clksrc_sequencer_tb.sv
module clksrc_sequencer_tb;
    localparam int TO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic [5:0] req_pll_mult = '0;
    logic [5:0] req_pll_odiv = '0;
    logic       rosc_ready, xosc_ready;
    logic       pll_lock = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       rosc_en, xosc_en, pll_sel, pll_bypass, pll_refsel, pll_odiv_by1;
    logic [5:0] rosc_div, pll_mult, pll_odiv;
    logic [4:0] rosc_trim;
    logic       busy, done, err;

    int n_cmp = 0, n_bad = 0;
    int rosc_cnt = 0, xosc_cnt = 0, rosc_dly = 2;
    bit xosc_dead = 1'b0, reported = 1'b0;
    int viol_r3 = 0, viol_r8 = 0, viol_r9 = 0;

    always #2 clk = ~clk;

    clksrc_sequencer #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_pll_mult(req_pll_mult), .req_pll_odiv(req_pll_odiv),
        .rosc_ready(rosc_ready), .xosc_ready(xosc_ready), .pll_lock(pll_lock),
        .rtc_tick(rtc_tick), .rosc_en(rosc_en), .rosc_div(rosc_div),
        .rosc_trim(rosc_trim), .xosc_en(xosc_en), .pll_sel(pll_sel),
        .pll_bypass(pll_bypass), .pll_refsel(pll_refsel), .pll_mult(pll_mult),
        .pll_odiv(pll_odiv), .pll_odiv_by1(pll_odiv_by1), .busy(busy),
        .done(done), .err(err)
    );

    // Oscillator models: ready some cycles after enable, drops with enable
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rosc_cnt <= 0;
            xosc_cnt <= 0;
        end else begin
            rosc_cnt <= rosc_en ? ((rosc_cnt < 100) ? rosc_cnt + 1 : rosc_cnt) : 0;
            xosc_cnt <= xosc_en ? ((xosc_cnt < 100) ? xosc_cnt + 1 : xosc_cnt) : 0;
        end
    end
    assign rosc_ready = rosc_en && (rosc_cnt >= rosc_dly);
    assign xosc_ready = xosc_en && !xosc_dead && (xosc_cnt >= 5);

    // Ordering monitors (R3, R8, R9)
    logic [14:0] prev_cfg;
    logic        prev_sel, prev_rosc;
    always @(negedge clk) begin
        if (rst_n) begin
            if ({pll_bypass, pll_refsel, pll_mult, pll_odiv, pll_odiv_by1} != prev_cfg) begin
                if (prev_sel)  viol_r8++;
                if (!rosc_en)  viol_r3++;
            end
            if (prev_rosc && !rosc_en && !pll_sel) viol_r9++;
        end
        prev_cfg  = {pll_bypass, pll_refsel, pll_mult, pll_odiv, pll_odiv_by1};
        prev_sel  = pll_sel;
        prev_rosc = rosc_en;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic request(input logic [1:0] m, input int mu, input int dv);
        @(negedge clk);
        req_valid    = 1'b1;
        req_mode     = m;
        req_pll_mult = 6'(mu);
        req_pll_odiv = 6'(dv);
        @(negedge clk);
        req_valid    = 1'b0;
        req_pll_mult = 6'd63;
        req_pll_odiv = 6'd63;
    endtask

    task automatic wait_done(input int maxc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic tick_pulse();
        @(negedge clk) rtc_tick = 1'b1;
        @(negedge clk) rtc_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1 rosc_en", rosc_en, 1);
        check_eq("R1 rosc_div", rosc_div, 4);
        check_eq("R1 rosc_trim", rosc_trim, 16);
        check_eq("R1 xosc_en", xosc_en, 0);
        check_eq("R1 pll_sel", pll_sel, 0);
        check_eq("R1 bypass", pll_bypass, 1);
        check_eq("R1 refsel", pll_refsel, 0);
        check_eq("R1 mult/odiv/by1", {pll_mult, pll_odiv, pll_odiv_by1}, 0);
        check_eq("R1 busy/done/err", {busy, done, err}, 0);
    endtask

    task automatic t_bad_mode();
        request(2'd3, 5, 5);
        check_eq("R2 mode3 busy", busy, 0);
        repeat (3) @(negedge clk);
        check_eq("R2 mode3 busy later", busy, 0);
        check_eq("R2 mode3 sel", pll_sel, 0);
    endtask

    task automatic t_internal();
        bit seen;
        request(2'd0, 0, 0);
        check_eq("R10 busy after accept", busy, 1);
        wait_done(100, seen);
        check_eq("R10 done seen", seen, 1);
        check_eq("R10 busy in done", busy, 1);
        @(negedge clk);
        check_eq("R10 done width", done, 0);
        check_eq("R10 busy cleared", busy, 0);
        check_eq("R4 sel", pll_sel, 0);
        check_eq("R4 bypass/refsel", {pll_bypass, pll_refsel}, 2'b10);
        check_eq("R4 xosc/rosc", {xosc_en, rosc_en}, 2'b01);
    endtask

    task automatic t_external();
        bit seen;
        request(2'd1, 0, 0);
        wait_done(200, seen);
        check_eq("R6 done without ticks", seen, 1);
        check_eq("R6 bypass/refsel/by1", {pll_bypass, pll_refsel, pll_odiv_by1}, 3'b111);
        check_eq("R6 sel/xosc/rosc", {pll_sel, xosc_en, rosc_en}, 3'b110);
        check_eq("R6 err", err, 0);
    endtask

    task automatic t_pll_early_lock();
        bit seen;
        request(2'd2, 20, 3);
        for (int i = 0; i < 200; i++) begin
            if (!pll_bypass) break;
            @(negedge clk);
        end
        check_eq("R7 config applied", pll_bypass, 0);
        check_eq("R5 xosc on before config", xosc_en, 1);
        check_eq("R7 sel low during config", pll_sel, 0);
        pll_lock = 1'b1;
        repeat (3) tick_pulse();
        repeat (10) @(negedge clk);
        check_eq("R7 lock ignored before 4 ticks", pll_sel, 0);
        request(2'd0, 0, 0);
        check_eq("R2 still busy", busy, 1);
        tick_pulse();
        wait_done(30, seen);
        check_eq("R7 done after 4th tick", seen, 1);
        check_eq("R2 busy request ignored, sel", pll_sel, 1);
        check_eq("R7 mult latched", pll_mult, 20);
        check_eq("R7 odiv latched", pll_odiv, 3);
        check_eq("R7 bypass/refsel/by1", {pll_bypass, pll_refsel, pll_odiv_by1}, 3'b010);
        check_eq("R9 rosc off", rosc_en, 0);
        pll_lock = 1'b0;
    endtask

    task automatic t_slow_rosc_back();
        bit seen;
        rosc_dly = 8;
        request(2'd0, 0, 0);
        repeat (3) @(negedge clk);
        check_eq("R3 stays on pll until rosc ready", pll_sel, 1);
        check_eq("R3 rosc enabled with defaults", {rosc_en, rosc_div, rosc_trim}, {1'b1, 6'd4, 5'd16});
        check_eq("R3 pll untouched", pll_bypass, 0);
        wait_done(100, seen);
        check_eq("R4 back to internal", {pll_sel, pll_bypass, pll_refsel, xosc_en}, 4'b0100);
        rosc_dly = 2;
    endtask

    task automatic t_late_lock();
        bit seen;
        request(2'd2, 9, 2);
        for (int i = 0; i < 200; i++) begin
            if (!pll_bypass) break;
            @(negedge clk);
        end
        repeat (4) tick_pulse();
        repeat (20) @(negedge clk);
        check_eq("R7 waits for lock", pll_sel, 0);
        pll_lock = 1'b1;
        wait_done(30, seen);
        check_eq("R7 done after lock", seen, 1);
        check_eq("R7 sel after lock", pll_sel, 1);
        check_eq("R7 mult", pll_mult, 9);
        pll_lock = 1'b0;
    endtask

    task automatic t_timeout();
        bit seen;
        xosc_dead = 1'b1;
        request(2'd1, 0, 0);
        wait_done(TO + 200, seen);
        check_eq("R11 done after timeout", seen, 1);
        check_eq("R11 err", err, 1);
        check_eq("R11 fallback", {pll_sel, pll_bypass, pll_refsel, xosc_en, rosc_en}, 5'b01001);
        xosc_dead = 1'b0;
        request(2'd1, 0, 0);
        check_eq("R11 err cleared", err, 0);
        wait_done(200, seen);
        check_eq("R11 recovered", {err, pll_sel}, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        repeat (5) @(negedge clk);
        t_bad_mode();
        t_internal();
        t_external();
        t_pll_early_lock();
        t_slow_rosc_back();
        t_late_lock();
        t_timeout();
        check_eq("R3 monitor", viol_r3, 0);
        check_eq("R8 monitor", viol_r8, 0);
        check_eq("R9 monitor", viol_r9, 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

endmodule